// File: doc/BRIEF.md
# Mixed-Sensitivity Interrupt Status Controller

This block collects seven event lines from a video processing pipeline into one status word that software reads through a small register port, and it drives a single interrupt request to the host. Each status bit has a fixed sensitivity. Four bits (0, 2, 3, 4) latch on a rising edge of their source and hold until software clears them. Three bits (1, 5, 6) mirror the live level of their source, one clock late.

The interrupt request is the global enable ANDed with the OR of all seven status bits, taken through a register. A write to the control word can also issue a one-cycle software reset strobe to the rest of the pipeline. The register port is a flat address, write enable, write data and read data interface. Read data is registered and reflects the addressed word one clock after the address is presented.

Bit meanings:

| Bit | Kind  | Event |
|-----|-------|-------|
| 0   | edge  | output frame complete |
| 1   | level | coefficient FIFO can take another coefficient |
| 2   | edge  | input line arrived before the pipeline was ready |
| 3   | edge  | frame period ended before output was complete |
| 4   | edge  | coefficient pushed while the FIFO was not ready |
| 5   | level | shadow values transferred to active registers |
| 6   | level | selected coefficient bank ready for readback |

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the status word, the enable bit, `irq`, `sw_rst` and `reg_rdata` are all zero.
- R2: The enable word at offset 0x21C holds a read/write bit 0 (1 = interrupts enabled). Its bits 31:1 always read as zero.
- R3: The status word at offset 0x220 returns the seven status bits in bits 6:0, and its bits 31:7 read as zero. Any address other than 0x21C and 0x220 reads as zero. `reg_rdata` shows the word addressed at the previous clock edge.
- R4: A single-cycle high pulse on an edge-type source (bits 0, 2, 3, 4) sets its status bit two clocks after the pulse starts. The bit then stays set after the source returns low.
- R5: An edge-type bit that is cleared while its source is held high stays clear until the source falls and rises again.
- R6: Writing the status word with a 1 in an edge-type bit position clears that bit. Writing 0 in that position leaves it unchanged.
- R7: If a clear of an edge-type bit lands on the same clock as a new rising edge of its source, the bit stays set.
- R8: A level-type bit (bits 1, 5, 6) equals its source sampled at the previous clock edge. Writes to the status word do not change it.
- R9: `irq` equals, one clock later, the enable bit ANDed with the OR of the seven status bits.
- R10: Writing offset 0x000 with bit 31 set raises `sw_rst` for exactly the following cycle. `sw_rst` stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| ev_in | input | 7 | One event line per status bit |
| irq | output | 1 | Registered interrupt request |
| sw_rst | output | 1 | One-cycle software reset strobe |

## Verification
The bench drives every source in turn in three ways:
- A one-cycle pulse, which must latch only on the edge-type bits and leave no trace on the level-type bits.
- A held-high level, which must show up on every bit.
- A held-high level with a clear in the middle. This separates true edge detection from plain level latching, because the cleared bit must not re-arm.

A clear that lands on the same clock as a fresh rising edge is set against a clear with no edge on a second bit, which shows that the edge takes precedence. The enable bit is toggled while status is pending, to show the gating and the one-cycle lag of the interrupt.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned NUM_SRC  = 7;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned SRST_BIT = 31;
  // 1 = rising-edge sticky bit, 0 = live level mirror
  localparam logic [NUM_SRC-1:0] EDGE_MASK = 7'b0011101;
  localparam logic [ADDR_W-1:0]  OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0]  OFS_GIE   = 12'h21C;
  localparam logic [ADDR_W-1:0]  OFS_ISR   = 12'h220;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic clr,
  output logic stat
);
  logic src_q1, src_q2, rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q1 <= 1'b0;
      src_q2 <= 1'b0;
    end else begin
      src_q1 <= src;
      src_q2 <= src_q1;
    end
  end

  assign rise = src_q1 & ~src_q2;

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) stat <= 1'b0;
    else     stat <= rise | (stat & ~clr);
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_stat_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  status,
  output logic          gie,
  output logic [N-1:0]  clr_edge,
  output logic          sw_rst,
  output logic [DW-1:0] rdata
);
  logic sel_ctrl, sel_gie, sel_isr;
  logic unused_wdata;

  assign sel_ctrl = (addr == AW'(OFS_CTRL));
  assign sel_gie  = (addr == AW'(OFS_GIE));
  assign sel_isr  = (addr == AW'(OFS_ISR));

  assign clr_edge = (wr && sel_isr) ? (wdata[N-1:0] & EDGE_MASK) : '0;

  assign unused_wdata = ^wdata[DW-2:N];

  always_ff @(posedge clk) begin
    if (rst) begin
      gie    <= 1'b0;
      sw_rst <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr && sel_gie) gie <= wdata[0];
      sw_rst <= wr && sel_ctrl && wdata[SRST_BIT];
      if (sel_gie)      rdata <= DW'(gie);
      else if (sel_isr) rdata <= DW'(status);
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [N-1:0]  ev_in,
  output logic          irq,
  output logic          sw_rst
);
  logic [N-1:0] stat;
  logic [N-1:0] clr_edge;
  logic         gie;

  irq_regfile #(.N(N), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .status(stat), .gie(gie), .clr_edge(clr_edge), .sw_rst(sw_rst),
    .rdata(reg_rdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      irq_edge_cap u_cap (
        .clk(clk), .rst(rst), .src(ev_in[i]), .clr(clr_edge[i]), .stat(stat[i])
      );
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) stat[i] <= 1'b0;
        else     stat[i] <= ev_in[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= gie & (|stat);
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_stat_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [N-1:0]  src,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  clr,
  input logic          gie,
  input logic          irq,
  input logic          sw_rst
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (stat[i] && !clr[i]) |=> stat[i]);
    end else begin : g_level
      assert_level_track_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (stat[i] == $past(src[i])));
    end
  end

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);

  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (gie && (|stat)) |=> irq);

  assert_srst_cause_R10: assert property (@(posedge clk) disable iff (rst)
    sw_rst |-> $past(wr && (addr == AW'(OFS_CTRL)) && wdata[SRST_BIT]));

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rdata[DW-1:N] == '0);
endmodule

bind irq_status_ctrl irq_status_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
  .rdata(reg_rdata), .src(ev_in), .stat(stat), .clr(clr_edge), .gie(gie),
  .irq(irq), .sw_rst(sw_rst)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  localparam logic [6:0]  EDGE = 7'b0011101;
  localparam logic [11:0] A_CTRL = 12'h000, A_GIE = 12'h21C, A_ISR = 12'h220;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [6:0]  ev_in;
  logic        irq;
  logic        sw_rst;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in),
    .irq(irq), .sw_rst(sw_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; ev_in = '0;
    idle(3);
    // R1: reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 sw_rst", {31'h0, sw_rst}, 32'h0);
    rst = 1'b0;
    rd(A_ISR, rv); check("R1 status", rv, 32'h0);
    rd(A_GIE, rv); check("R1 gie", rv, 32'h0);

    // R2: enable register, reserved bits
    wr(A_GIE, 32'hFFFF_FFFF);
    rd(A_GIE, rv); check("R2 gie set", rv, 32'h1);
    wr(A_GIE, 32'hFFFF_FFFE);
    rd(A_GIE, rv); check("R2 gie clear", rv, 32'h0);

    // R3: unmapped addresses read zero
    rd(12'h224, rv); check("R3 unmapped", rv, 32'h0);
    rd(A_CTRL, rv);  check("R3 ctrl reads zero", rv, 32'h0);

    // R4/R8: one-cycle pulse per source
    for (int i = 0; i < 7; i++) begin
      logic [31:0] exp;
      @(negedge clk); ev_in = 7'(1 << i);
      @(negedge clk); ev_in = '0;
      idle(1);
      exp = EDGE[i] ? 32'(1 << i) : 32'h0;
      rd(A_ISR, rv);
      check(EDGE[i] ? "R4 pulse latched" : "R8 pulse not held", rv, exp);
      wr(A_ISR, 32'h7F);
      rd(A_ISR, rv); check("R6 clear all", rv, 32'h0);
    end

    // R8: held levels on every bit
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); ev_in = 7'(1 << i);
      idle(2);
      rd(A_ISR, rv); check("R8/R4 held high", rv, 32'(1 << i));
      wr(A_ISR, 32'h7F);   // R5/R8: clear while held
      idle(2);
      rd(A_ISR, rv);
      check(EDGE[i] ? "R5 no re-arm" : "R8 write ignored", rv, EDGE[i] ? 32'h0 : 32'(1 << i));
      @(negedge clk); ev_in = '0;
      idle(2);
      rd(A_ISR, rv); check("R8 released", rv, 32'h0);
    end

    // R6: writing zero leaves edge bits; selective clear
    @(negedge clk); ev_in = 7'b0011101;
    @(negedge clk); ev_in = '0;
    idle(1);
    wr(A_ISR, 32'h0);
    rd(A_ISR, rv); check("R6 write zero keeps", rv, 32'h1D);
    wr(A_ISR, 32'h05);
    rd(A_ISR, rv); check("R6 partial clear", rv, 32'h18);

    // R9: interrupt gating (status 0x18 pending, gie off)
    check("R9 irq gated", {31'h0, irq}, 32'h0);
    wr(A_GIE, 32'h1);
    check("R9 irq lag", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    wr(A_ISR, 32'h7F);
    @(negedge clk);
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    @(negedge clk); ev_in = 7'b0100000;
    idle(2);
    check("R9 level drives irq", {31'h0, irq}, 32'h1);
    @(negedge clk); ev_in = '0;
    idle(2);
    check("R9 level release", {31'h0, irq}, 32'h0);

    // R7: clear colliding with a new edge on bit 2; bit 3 cleared plainly
    @(negedge clk); ev_in = 7'b0001100;
    @(negedge clk); ev_in = '0;
    idle(2);
    @(negedge clk); ev_in[2] = 1'b1;
    @(negedge clk); reg_addr = A_ISR; reg_wr = 1'b1; reg_wdata = 32'h0C;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0; ev_in = '0;
    rd(A_ISR, rv); check("R7 edge beats clear", rv, 32'h04);
    wr(A_ISR, 32'h7F);

    // R10: software reset strobe
    wr(A_CTRL, 32'h7FFF_FFFF);
    check("R10 no strobe", {31'h0, sw_rst}, 32'h0);
    wr(A_CTRL, 32'h8000_0000);
    check("R10 strobe", {31'h0, sw_rst}, 32'h1);
    @(negedge clk);
    check("R10 single cycle", {31'h0, sw_rst}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule